// File: doc/BRIEF.md
# Serial Data Link Receive Byte Matcher

This block gathers the bits of a serial data link channel into bytes. The framer that feeds it locates the data link positions in the line frame, removes any stuffed zeros, and then hands over one bit at a time with a valid strobe. Every eighth accepted bit completes a byte. The block copies that byte into a receive register that the host can read.

Each completed byte is compared with two match values that the host programs. An equal byte sets a sticky match flag. Every loaded byte also sets a sticky byte-ready flag. The two flags sit in a status register that is cleared when the host reads it. Each flag has an enable bit in a mask register. The active-low interrupt line is driven low while any enabled flag is set.

The host port is a simple synchronous register port with a 3-bit address. It has these registers:
- 0: receive byte, read-only
- 1: first match value, read/write
- 2: second match value, read/write
- 3: interrupt mask, read/write; bit 0 enables byte-ready, bit 1 enables match
- 4: status, read-to-clear; bit 0 byte-ready, bit 1 match

Unused bits read as zero.

Top module: `dlink_rx_matcher`

## Requirements
- R1: Accepted bits are assembled least significant bit first. The first accepted bit of a byte lands in bit 0 of the receive register, and the eighth lands in bit 7.
- R2: The receive register (address 0, also on `rxByte`) is loaded on the clock edge that follows the edge that accepted the eighth bit. It keeps its value at all other times.
- R3: The host can write the two match registers (addresses 1 and 2) and the mask register (address 3, 2 bits), and reads the written values back.
- R4: A loaded byte equal to the first match register sets status bit 1 (match) on the same edge that loads the receive register.
- R5: A loaded byte equal to the second match register also sets status bit 1. A byte equal to neither leaves it unchanged.
- R6: Every byte load sets status bit 0 (byte-ready).
- R7: Status bits are sticky. A host read of address 4 clears them both on that edge, except that a bit set on the same edge stays set.
- R8: `irqN` is low exactly while (status AND mask) is nonzero. With a mask bit at zero, the corresponding flag never pulls `irqN` low.
- R9: A synchronous reset clears the partial byte, the bit count, the receive register, the status, the mask and both match registers.
- R10: `bitIn` is ignored in any cycle where `bitValid` is low. It neither enters the byte nor advances the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | Framer strobe: `bitIn` is a data link bit this cycle |
| bitIn | input | 1 | Serial data link bit |
| hostWe | input | 1 | Host register write enable |
| hostRe | input | 1 | Host register read strobe (a read of address 4 clears status) |
| hostAddr | input | 3 | Host register address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data for `hostAddr`, combinational |
| rxByte | output | 8 | Current receive register |
| statusOut | output | 2 | Status flags: bit 1 match, bit 0 byte-ready |
| irqN | output | 1 | Interrupt, active low |

## Verification
On every cycle, the assertions check the following:
- reset clears the flags;
- each byte load is followed by the byte-ready flag;
- the receive register holds steady when no load occurs;
- the match flag persists until a status read;
- a status read without a coincident load empties the status;
- `irqN` stays high with empty status.

Several properties can only be shown by the bench's scenarios, which compare every clock against a behavioural model:
- the LSB-first bit order;
- equality against each match register;
- the new-match-wins race against a status read;
- the effect of the mask on `irqN`;
- the idle cycles in which `bitIn` toggles with `bitValid` low.

// File: rtl/dlink_rx_pkg.sv
package dlink_rx_pkg;

  typedef struct packed {
    logic shiftEn;
    logic loadByte;
    logic clearStat;
  } dl_strobe_t;

  localparam int STAT_W = 2;
  localparam int STAT_READY = 0;
  localparam int STAT_MATCH = 1;

  localparam int ADDR_RX = 0;
  localparam int ADDR_MATCH0 = 1;

endpackage

// File: rtl/dlink_rx_ctrl.sv
module dlink_rx_ctrl
  import dlink_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int STAT_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              hostRe,
  input  logic [ADDR_W-1:0] hostAddr,
  output dl_strobe_t        strobes
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             loadPend;

  // Count accepted bits; flag a byte load for the following edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt   <= '0;
      loadPend <= 1'b0;
    end else begin
      loadPend <= bitValid && (bitCnt == LAST_BIT);
      if (bitValid) begin
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.shiftEn   = bitValid;
    strobes.loadByte  = loadPend;
    strobes.clearStat = hostRe && (hostAddr == ADDR_W'(STAT_ADDR));
  end

endmodule

// File: rtl/dlink_rx_dpath.sv
module dlink_rx_dpath
  import dlink_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NUM_MATCH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dl_strobe_t        strobes,
  input  logic              bitIn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] rxByte,
  output logic [STAT_W-1:0] statusOut,
  output logic              irqN
);

  localparam int MASK_ADDR = ADDR_MATCH0 + NUM_MATCH;
  localparam int STAT_ADDR = MASK_ADDR + 1;

  logic [DATA_W-1:0]    shiftReg;
  logic [DATA_W-1:0]    matchReg [NUM_MATCH];
  logic [NUM_MATCH-1:0] hitVec;
  logic [STAT_W-1:0]    maskReg;
  logic [STAT_W-1:0]    statReg;
  logic [STAT_W-1:0]    statSet;

  // LSB-first assembly: new bits enter at the top and move down.
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= {bitIn, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxByte <= '0;
    end else if (strobes.loadByte) begin
      rxByte <= shiftReg;
    end
  end

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
    always_ff @(posedge clk) begin
      if (rst) begin
        matchReg[g] <= '0;
      end else if (hostWe && hostAddr == ADDR_W'(ADDR_MATCH0 + g)) begin
        matchReg[g] <= hostWdata;
      end
    end
    assign hitVec[g] = (shiftReg == matchReg[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg <= '0;
    end else if (hostWe && hostAddr == ADDR_W'(MASK_ADDR)) begin
      maskReg <= hostWdata[STAT_W-1:0];
    end
  end

  always_comb begin
    statSet = '0;
    statSet[STAT_READY] = strobes.loadByte;
    statSet[STAT_MATCH] = strobes.loadByte && (|hitVec);
  end

  // A fresh set wins over a clearing read in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      statReg <= '0;
    end else begin
      statReg <= statSet | (strobes.clearStat ? '0 : statReg);
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostAddr == ADDR_W'(ADDR_RX)) begin
      hostRdata = rxByte;
    end else if (hostAddr == ADDR_W'(MASK_ADDR)) begin
      hostRdata[STAT_W-1:0] = maskReg;
    end else if (hostAddr == ADDR_W'(STAT_ADDR)) begin
      hostRdata[STAT_W-1:0] = statReg;
    end else begin
      for (int i = 0; i < NUM_MATCH; i++) begin
        if (hostAddr == ADDR_W'(ADDR_MATCH0 + i)) begin
          hostRdata = matchReg[i];
        end
      end
    end
  end

  assign statusOut = statReg;
  assign irqN = ~|(statReg & maskReg);

endmodule

// File: rtl/dlink_rx_matcher.sv
module dlink_rx_matcher
  import dlink_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NUM_MATCH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] rxByte,
  output logic [1:0]        statusOut,
  output logic              irqN
);

  localparam int STAT_ADDR = ADDR_MATCH0 + NUM_MATCH + 1;

  dl_strobe_t strobes;

  dlink_rx_ctrl #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .STAT_ADDR(STAT_ADDR)
  ) ctrl (
    .clk(clk),
    .rst(rst),
    .bitValid(bitValid),
    .hostRe(hostRe),
    .hostAddr(hostAddr),
    .strobes(strobes)
  );

  dlink_rx_dpath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .NUM_MATCH(NUM_MATCH)
  ) dpath (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .bitIn(bitIn),
    .hostWe(hostWe),
    .hostAddr(hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .rxByte(rxByte),
    .statusOut(statusOut),
    .irqN(irqN)
  );

endmodule

// File: rtl/dlink_rx_matcher_chk.sv
module dlink_rx_matcher_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int STAT_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hostRe,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] rxByte,
  input logic [1:0]        statusOut,
  input logic              irqN,
  input logic              loadByte
);

  logic statRead;
  assign statRead = hostRe && (hostAddr == ADDR_W'(STAT_ADDR));

  p_reset_clears_r9: assert property (@(posedge clk)
    $past(rst) |-> (statusOut == 2'b00 && rxByte == '0));

  p_ready_after_load_r6: assert property (@(posedge clk) disable iff (rst)
    loadByte |=> statusOut[0]);

  p_rx_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !loadByte |=> $stable(rxByte));

  p_match_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (statusOut[1] && !statRead) |=> statusOut[1]);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (statRead && !loadByte) |=> (statusOut == 2'b00));

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (statusOut == 2'b00) |-> irqN);

endmodule

bind dlink_rx_matcher dlink_rx_matcher_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .STAT_ADDR(STAT_ADDR)
) chk (
  .clk(clk),
  .rst(rst),
  .hostRe(hostRe),
  .hostAddr(hostAddr),
  .rxByte(rxByte),
  .statusOut(statusOut),
  .irqN(irqN),
  .loadByte(strobes.loadByte)
);

// File: tb/dlink_rx_matcher_test.sv
module dlink_rx_matcher_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic       hostWe = 1'b0;
  logic       hostRe = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic [7:0] hostWdata = 8'd0;
  logic [7:0] hostRdata;
  logic [7:0] rxByte;
  logic [1:0] statusOut;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dlink_rx_matcher uut (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .rxByte(rxByte),
    .statusOut(statusOut), .irqN(irqN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference model
  bit   bitQ[$];
  bit   mPend = 0;
  int   mPendVal = 0;
  int   mRx = 0, mA = 0, mB = 0, mMask = 0, mStat = 0;

  always @(posedge clk) begin
    if (rst) begin
      bitQ.delete();
      mPend = 0; mRx = 0; mA = 0; mB = 0; mMask = 0; mStat = 0;
    end else begin
      if (hostRe && hostAddr == 3'd4) mStat = 0;
      if (mPend) begin
        mRx = mPendVal;
        mStat = mStat | 1;
        if (mPendVal == mA || mPendVal == mB) mStat = mStat | 2;
      end
      if (hostWe) begin
        if (hostAddr == 3'd1) mA = hostWdata;
        if (hostAddr == 3'd2) mB = hostWdata;
        if (hostAddr == 3'd3) mMask = hostWdata & 3;
      end
      mPend = 0;
      if (bitValid) begin
        bitQ.push_back(bitIn);
        if (bitQ.size() == 8) begin
          mPendVal = 0;
          for (int i = 0; i < 8; i++) if (bitQ[i]) mPendVal = mPendVal | (1 << i);
          bitQ.delete();
          mPend = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int modelRdata(input int a);
    case (a)
      0: return mRx;
      1: return mA;
      2: return mB;
      3: return mMask;
      4: return mStat;
      default: return 0;
    endcase
  endfunction

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1/R2 rxByte", rxByte, mRx);
      check("R4/R5 match flag", statusOut[1], (mStat >> 1) & 1);
      check("R6 ready flag", statusOut[0], mStat & 1);
      check("R8 irqN", irqN, ((mStat & mMask) != 0) ? 0 : 1);
      check("R3 hostRdata", hostRdata, modelRdata(hostAddr));
    end
  end

  task automatic drive(input bit v, input bit b, input bit we, input bit re,
                       input int a, input int wd);
    bitValid = v; bitIn = b; hostWe = we; hostRe = re;
    hostAddr = 3'(a); hostWdata = 8'(wd);
    @(posedge clk); #2;
    bitValid = 0; hostWe = 0; hostRe = 0;
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0, 0); endtask

  // R10: gaps with bitIn toggling while bitValid is low
  task automatic sendByte(input int val, input bit gaps);
    for (int i = 0; i < 8; i++) begin
      if (gaps) begin
        drive(0, ~val[i], 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0);
      end
      drive(1, val[i], 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset rxByte", rxByte, 0);
    check("R9 reset status", statusOut, 0);
    check("R9 reset irqN", irqN, 1);
    rst = 0;
    idle();
    drive(0, 0, 1, 0, 1, 8'hA5);
    drive(0, 0, 1, 0, 2, 8'h3C);
    drive(0, 0, 1, 0, 3, 2);
    hostAddr = 3'd1; #1; check("R3 matchA readback", hostRdata, 8'hA5);
    hostAddr = 3'd2; #1; check("R3 matchB readback", hostRdata, 8'h3C);
    hostAddr = 3'd0;

    sendByte(8'h5A, 0); idle();
    check("R1 LSB first nonmatch", rxByte, 8'h5A);
    check("R5 nonmatch leaves flag", statusOut, 2'b01);
    check("R8 masked ready keeps irq high", irqN, 1);
    drive(0, 0, 0, 1, 4, 0);
    check("R7 read clears", statusOut, 0);

    sendByte(8'hA5, 1); idle();
    check("R4 matchA sets flag", statusOut, 2'b11);
    check("R10 gaps ignored", rxByte, 8'hA5);
    check("R8 irq low on match", irqN, 0);
    drive(0, 0, 0, 1, 4, 0);

    sendByte(8'h3C, 0);
    drive(0, 0, 0, 1, 4, 0);   // read on the load edge
    check("R7 set wins over read", statusOut, 2'b11);
    check("R2 load after eighth bit", rxByte, 8'h3C);
    idle(); idle();
    check("R7 sticky", statusOut, 2'b11);
    drive(0, 0, 0, 1, 4, 0);
    check("R7 cleared", statusOut, 0);

    drive(0, 0, 1, 0, 3, 0);
    sendByte(8'h3C, 1); idle();
    check("R8 mask zero irq high", irqN, 1);
    drive(0, 0, 1, 0, 3, 1);
    check("R8 ready enable irq low", irqN, 0);

    // partial byte then reset
    for (int i = 0; i < 5; i++) drive(1, 1, 0, 0, 0, 0);
    rst = 1; idle(); rst = 0;
    check("R9 reset status", statusOut, 0);
    hostAddr = 3'd1; #1; check("R9 match cleared", hostRdata, 0);
    hostAddr = 3'd0;
    sendByte(8'hC3, 0); idle();
    check("R9 bit count restarted", rxByte, 8'hC3);
    for (int k = 0; k < 20; k++) sendByte((k * 37 + 11) & 8'hFF, k[0]);
    idle(); idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule